// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns a single PWM command into the two gate enables of a synchronous buck half-bridge: a high-side enable that follows the command and a low-side enable that is its complement. Both enables are never on together. Every handover passes through a dead interval in which both are off.

When the high side hands over to the low side, the dead interval adapts to a switch-node comparator (`sw_above`, high while the node sits above about 1 V). It ends as soon as the node is seen high and then seen to drop. If the node was never seen high, a fixed fallback delay ends it instead. If the node stays up, a hard timeout ends it, which covers reverse inductor current. When the low side hands over to the high side, the sequencer waits for a low-side gate comparator (`lsg_low`, high once the low-side gate is below about a sixth of the supply) and then a fixed hold.

An enable input (`gate_en`, active low disable) forces both gates off while it is low. All four inputs are asynchronous and pass through a two-stage synchronizer. An input change therefore shows at the outputs no earlier than the third rising clock edge after it. Each delay is counted from the clock edge at which its state is entered.

The states are:
- IDLE: disabled or just out of reset.
- HIGH: high side on.
- FALL_GAP: dead time from high side to low side.
- LOW: low side on.
- RISE_WAIT: waiting for the low-side gate comparator.
- RISE_HOLD: fixed hold before the high side turns on.

The transitions are:
- Any state to IDLE while the enable is low.
- IDLE to RISE_WAIT or FALL_GAP, chosen by the command level.
- HIGH to FALL_GAP when the command falls.
- FALL_GAP to LOW on threshold, fallback or timeout.
- FALL_GAP to RISE_WAIT when the command rises again.
- LOW to RISE_WAIT when the command rises.
- RISE_WAIT to RISE_HOLD on the comparator.
- RISE_HOLD to HIGH when the hold expires.
- RISE_WAIT or RISE_HOLD to FALL_GAP when the command falls again.

Top module: `deadtime_gate_seq`

## Requirements
- R1: `hs_gate` and `ls_gate` are never both 1. Each of them rises only after a cycle in which the other was 0.
- R2: In steady state `hs_gate` equals the command and `ls_gate` its complement. A command change clears the conducting gate at the third rising edge after the change.
- R3: While `gate_en` is 0 (synchronized), both gates are 0 from the third edge after it falls, whatever the command or the comparators do.
- R4: After `gate_en` returns to 1 the sequencer starts from IDLE. It reaches a gate only through RISE_WAIT/RISE_HOLD or FALL_GAP, never directly.
- R5: In FALL_GAP, if `sw_above` was seen 1 during the current HIGH/FALL_GAP period, `ls_gate` rises at the edge after the synchronized `sw_above` is first seen 0.
- R6: If `sw_above` was not seen 1 in the period, `ls_gate` rises FALLBACK_CYC cycles after entering FALL_GAP (default 12).
- R7: If `sw_above` stays 1, `ls_gate` rises TIMEOUT_CYC cycles after entering FALL_GAP (default 24).
- R8: After the command rises, `hs_gate` stays 0 until the synchronized `lsg_low` is 1. It then rises HOLD_CYC cycles after entering RISE_HOLD (default 4).
- R9: A command reversal during any dead interval abandons the pending turn-on. The opposite transition starts with both gates still 0.
- R10: During reset both gates are 0. After reset the sequencer starts in IDLE and reaches the low side through FALL_GAP (fallback path when the node is low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_cmd | input | 1 | PWM command, asynchronous |
| gate_en | input | 1 | 0 forces both gates off, asynchronous |
| sw_above | input | 1 | Switch node above about 1 V |
| lsg_low | input | 1 | Low-side gate below about a sixth of supply |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The delicate coincidence is a PWM reversal arriving while a dead-time count is still running. The question is whether the count expiring and the reversal can both be honoured, which would open a gate against the new command. The bench reverses the command partway through a fallback wait and partway through a rise wait. It expects the gate that was pending to stay closed at the cycle where it would otherwise have opened. It also expects the opposite gate to open on the exact cycle that a fresh transition predicts. Disable is likewise asserted while the high side is conducting and the command keeps toggling, and both gates are judged at fixed cycles to remain low.

// File: rtl/dt_seq_pkg.sv
package dt_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIGH,
        ST_FALL_GAP,
        ST_LOW,
        ST_RISE_WAIT,
        ST_RISE_HOLD
    } phase_e;
endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clr)            cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dt_fsm.sv
module dt_fsm
    import dt_seq_pkg::*;
#(
    parameter int FALLBACK_CYC = 12,
    parameter int TIMEOUT_CYC  = 24,
    parameter int HOLD_CYC     = 4,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s_pwm,
    input  logic             s_en,
    input  logic             s_sw,
    input  logic             s_lsg,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             cnt_clr,
    output logic             hs_o,
    output logic             ls_o
);
    localparam logic [CNT_W-1:0] FB_LAST   = CNT_W'(FALLBACK_CYC - 1);
    localparam logic [CNT_W-1:0] TO_LAST   = CNT_W'(TIMEOUT_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    phase_e st, nx;
    logic   seen_q;
    logic   in_hi_period, nx_hi_period;

    assign in_hi_period = (st == ST_HIGH) || (st == ST_FALL_GAP);
    assign nx_hi_period = (nx == ST_HIGH) || (nx == ST_FALL_GAP);

    always_comb begin
        nx = st;
        if (!s_en) begin
            nx = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:      nx = s_pwm ? ST_RISE_WAIT : ST_FALL_GAP;
                ST_HIGH:      if (!s_pwm) nx = ST_FALL_GAP;
                ST_FALL_GAP: begin
                    if (s_pwm)                            nx = ST_RISE_WAIT;
                    else if (seen_q && !s_sw)             nx = ST_LOW;
                    else if (!seen_q && cnt_i == FB_LAST) nx = ST_LOW;
                    else if (cnt_i == TO_LAST)            nx = ST_LOW;
                end
                ST_LOW:       if (s_pwm) nx = ST_RISE_WAIT;
                ST_RISE_WAIT: begin
                    if (!s_pwm)     nx = ST_FALL_GAP;
                    else if (s_lsg) nx = ST_RISE_HOLD;
                end
                ST_RISE_HOLD: begin
                    if (!s_pwm)                  nx = ST_FALL_GAP;
                    else if (cnt_i == HOLD_LAST) nx = ST_HIGH;
                end
                default:      nx = ST_IDLE;
            endcase
        end
    end

    assign cnt_clr = (nx != st);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            seen_q <= 1'b0;
        end else begin
            st     <= nx;
            seen_q <= (in_hi_period && nx_hi_period) ? (seen_q | s_sw) : 1'b0;
        end
    end

    always_comb begin
        hs_o = 1'b0;
        ls_o = 1'b0;
        unique case (st)
            ST_HIGH: hs_o = 1'b1;
            ST_LOW:  ls_o = 1'b1;
            default: ;
        endcase
    end

    // R1
    ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> !$past(hs_o));
    // R1
    hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> !$past(ls_o));
    // R3
    dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s_en |=> (!hs_o && !ls_o));
    // R7
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FALL_GAP) |-> (cnt_i < CNT_W'(TIMEOUT_CYC)));
    // R8
    hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_o) |-> ($past(st) == ST_RISE_HOLD && $past(cnt_i) == HOLD_LAST));
    // R4
    ls_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_o) |-> ($past(st) == ST_FALL_GAP));
endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq #(
    parameter int FALLBACK_CYC = 12,
    parameter int TIMEOUT_CYC  = 24,
    parameter int HOLD_CYC     = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_cmd,
    input  logic gate_en,
    input  logic sw_above,
    input  logic lsg_low,
    output logic hs_gate,
    output logic ls_gate
);
    localparam int N_IN  = 4;
    localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic [N_IN-1:0]  raw_in, syn_in;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;

    assign raw_in = {pwm_cmd, gate_en, sw_above, lsg_low};

    dt_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (syn_in)
    );

    dt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    dt_fsm #(
        .FALLBACK_CYC (FALLBACK_CYC),
        .TIMEOUT_CYC  (TIMEOUT_CYC),
        .HOLD_CYC     (HOLD_CYC),
        .CNT_W        (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_pwm   (syn_in[3]),
        .s_en    (syn_in[2]),
        .s_sw    (syn_in[1]),
        .s_lsg   (syn_in[0]),
        .cnt_i   (cnt),
        .cnt_clr (cnt_clr),
        .hs_o    (hs_gate),
        .ls_o    (ls_gate)
    );
endmodule

// File: tb/sim_deadtime_gate_seq.sv
module sim_deadtime_gate_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_cmd = 1'b0, gate_en = 1'b1, sw_above = 1'b0, lsg_low = 1'b1;
    logic hs_gate, ls_gate;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        logic  hs;
        logic  ls;
        string tag;
    } exp_t;
    exp_t sbq[$];
    exp_t item;

    always #5 clk = ~clk;

    deadtime_gate_seq u0 (
        .clk(clk), .rst_n(rst_n), .pwm_cmd(pwm_cmd), .gate_en(gate_en),
        .sw_above(sw_above), .lsg_low(lsg_low), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    // monitor: pops expected items on their cycle, checks overlap every cycle
    always begin
        @(posedge clk);
        cyc = cyc + 1;
        #2;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            item = sbq.pop_front();
            checks++;
            if (item.at != cyc || hs_gate !== item.hs || ls_gate !== item.ls) begin
                errors++;
                $display("FAIL %s cyc %0d: hs/ls=%b%b expected %b%b (due %0d)",
                         item.tag, cyc, hs_gate, ls_gate, item.hs, item.ls, item.at);
            end
        end
        if (rst_n) begin
            checks++;
            if (hs_gate && ls_gate) begin
                errors++;
                $display("FAIL R1 cyc %0d: hs/ls=11 expected not both", cyc);
            end
        end
    end

    task automatic push(input int at, input logic h, input logic l, input string tag);
        exp_t e;
        e.at = at; e.hs = h; e.ls = l; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // from LOW with lsg_low=0: command high, comparator later (R2, R8)
    task automatic go_high();
        int b, b2;
        @(negedge clk); b = cyc;
        pwm_cmd = 1'b1;
        push(b + 2, 1'b0, 1'b1, "R2");
        push(b + 3, 1'b0, 1'b0, "R8");
        idle(5); b2 = cyc;
        lsg_low = 1'b1;
        push(b2 + 6, 1'b0, 1'b0, "R8");
        push(b2 + 7, 1'b1, 1'b0, "R8");
        idle(10);
    endtask

    initial begin
        int p, q, b, r;
        idle(3);
        checks++;
        if (hs_gate !== 1'b0 || ls_gate !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: hs/ls=%b%b expected 00", hs_gate, ls_gate);
        end
        @(negedge clk); b = cyc;
        rst_n = 1'b1;
        push(b + 14, 1'b0, 1'b0, "R10");
        push(b + 15, 1'b0, 1'b1, "R10");
        idle(18);
        lsg_low = 1'b0;
        idle(2);

        go_high();

        // R5 threshold path
        sw_above = 1'b1;
        idle(4);
        @(negedge clk); p = cyc;
        pwm_cmd = 1'b0;
        push(p + 2, 1'b1, 1'b0, "R2");
        push(p + 3, 1'b0, 1'b0, "R5");
        idle(5); q = cyc;
        sw_above = 1'b0;
        push(q + 2, 1'b0, 1'b0, "R5");
        push(q + 3, 1'b0, 1'b1, "R5");
        idle(6);
        lsg_low = 1'b0;
        idle(2);

        // R6 fallback
        go_high();
        @(negedge clk); p = cyc;
        pwm_cmd = 1'b0;
        push(p + 3, 1'b0, 1'b0, "R6");
        push(p + 14, 1'b0, 1'b0, "R6");
        push(p + 15, 1'b0, 1'b1, "R6");
        idle(18);
        lsg_low = 1'b0;
        idle(2);

        // R7 timeout
        go_high();
        sw_above = 1'b1;
        idle(4);
        @(negedge clk); p = cyc;
        pwm_cmd = 1'b0;
        push(p + 3, 1'b0, 1'b0, "R7");
        push(p + 26, 1'b0, 1'b0, "R7");
        push(p + 27, 1'b0, 1'b1, "R7");
        idle(30);
        sw_above = 1'b0;
        lsg_low = 1'b0;
        idle(4);

        // R9 reversal during rise wait
        @(negedge clk); b = cyc;
        pwm_cmd = 1'b1;
        push(b + 3, 1'b0, 1'b0, "R9");
        idle(4);
        pwm_cmd = 1'b0;
        push(b + 18, 1'b0, 1'b0, "R9");
        push(b + 19, 1'b0, 1'b1, "R9");
        idle(22);

        // R9 reversal during fall gap
        go_high();
        @(negedge clk); p = cyc;
        pwm_cmd = 1'b0;
        push(p + 3, 1'b0, 1'b0, "R9");
        idle(5);
        pwm_cmd = 1'b1;
        push(p + 12, 1'b0, 1'b0, "R9");
        push(p + 13, 1'b1, 1'b0, "R9");
        push(p + 15, 1'b1, 1'b0, "R9");
        idle(18);

        // R3 disable while high, command toggling
        @(negedge clk); b = cyc;
        gate_en = 1'b0;
        push(b + 2, 1'b1, 1'b0, "R3");
        push(b + 3, 1'b0, 1'b0, "R3");
        idle(4); b = cyc;
        pwm_cmd = 1'b0;
        push(b + 18, 1'b0, 1'b0, "R3");
        idle(20); b = cyc;
        pwm_cmd = 1'b1;
        sw_above = 1'b1;
        push(b + 8, 1'b0, 1'b0, "R3");
        idle(10);
        sw_above = 1'b0;
        lsg_low = 1'b1;
        idle(2);

        // R4 release resumes through the rise path
        @(negedge clk); r = cyc;
        gate_en = 1'b1;
        push(r + 3, 1'b0, 1'b0, "R4");
        push(r + 7, 1'b0, 1'b0, "R4");
        push(r + 8, 1'b1, 1'b0, "R4");
        idle(12);

        checks++;
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left expected 0", sbq.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule